// File: doc/BRIEF.md
# Iterative 96-bit Substitution-Permutation Cipher Core

This core runs one full round of a lightweight 96-bit block cipher in every clock cycle. The block is held as a matrix of bytes with 3 rows and 4 columns. A one-cycle `start` strobe captures a block and folds in the first subkey. The core then steps through the rounds and returns the result together with a one-cycle `done` pulse. Each round substitutes every byte, moves bytes within rows, mixes each column and adds the round subkey. The last round skips the column mixing.

Subkeys come from a separate key unit. The core publishes the index of the subkey it needs on `key_sel`, and the key unit answers on `subkey` in the same cycle. The S-box is built from two 4-bit lookup tables that are passed in as parameters. The row moves and the column mixing undo themselves when applied twice. Decryption can therefore run on the same datapath, provided the key unit supplies suitably prepared subkeys in reverse order and the S-box tables form an involution.

Top module: `spn96_core`

## Requirements
- R1: After reset, `busy`, `done`, `key_sel` and `blk_out` are all zero.
- R2: Byte (row i, column j) of the matrix sits at `blk[8*(i+3*j) +: 8]`. The same mapping applies to `blk_in`, `subkey` and `blk_out`.
- R3: At the edge that accepts `start`, the state becomes `blk_in XOR subkey`, with `key_sel` equal to 0 in that cycle.
- R4: The S-box maps byte u with tables P and Q (entry n at bits [4n+3:4n]) in three steps. Step 1: h=P[u[7:4]], l=Q[u[3:0]]. Step 2: h2=Q[{h[3:2],l[3:2]}], l2=P[{h[1:0],l[1:0]}]. Step 3: h3=P[{h2[3:2],l2[3:2]}], l3=Q[{h2[1:0],l2[1:0]}]. The output is {h3,l3}.
- R5: The permutation leaves row 0 as it is. In row 1 it exchanges columns 0 and 1, and columns 2 and 3. In row 2 it exchanges columns 0 and 2, and columns 1 and 3.
- R6: Column mixing forms v=b0^b1^b2 and outputs (b0^D(v), b1^D(D(v)), b2^D(v)^D(D(v))). D(a) doubles a in GF(2^8) modulo x^8+x^6+x^3+x^2+1, which gives `{a[6:0],0}^(a[7]?8'h4D:0)`.
- R7: Round r (1..ROUNDS) computes subkey XOR mix(perm(sub(state))), with `key_sel`=r during that cycle. The final round leaves out the mixing step.
- R8: `done` rises ROUNDS clock edges after the edge that accepts `start`. During a run, `key_sel` counts 1,2,...,ROUNDS, one step per cycle.
- R9: `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored. The current run finishes unchanged and no extra run follows.
- R11: `blk_out` changes only together with a `done` pulse and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe, taken only while idle |
| blk_in | input | 96 | Block to process |
| subkey | input | 96 | Subkey selected by `key_sel` |
| key_sel | output | CNT_W | Index of the subkey needed this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| blk_out | output | 96 | Result of the last run |

## Verification
The bench first runs directed blocks: all-zero and all-one data and keys, and a single set bit. These expose stuck or misrouted bytes, errors in the byte-index mapping, and a wrong reduction constant in the doubling. It then runs seeded random blocks with fresh random subkeys per run, compared against a bench model of the rounds. A mismatch in the S-box step order, the row moves, the column mixing or the last-round exception shows up there. Extra strobes issued in mid-run must leave the result and the run length untouched. Idle cycles after completion must keep the output steady.

// File: rtl/spn96_pkg.sv
package spn96_pkg;
  localparam int ROWS   = 3;
  localparam int COLS   = 4;
  localparam int NBYTES = ROWS * COLS;
  localparam int BLK_W  = 8 * NBYTES;

  // multiply by x modulo x^8+x^6+x^3+x^2+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h4D : 8'h00);
  endfunction

  function automatic logic [3:0] nib_lut(input logic [63:0] tbl, input logic [3:0] idx);
    return tbl[4*idx +: 4];
  endfunction

  // column swap distance for each row of the permutation
  function automatic int row_swap(input int row);
    return (row == 0) ? 0 : ((row == 1) ? 1 : 2);
  endfunction
endpackage

// File: rtl/spn96_sbox.sv
module spn96_sbox #(
  parameter logic [63:0] P_BOX = 64'h3FE054BCDA967821,
  parameter logic [63:0] Q_BOX = 64'h9E5D4C7A8B2F1036
) (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import spn96_pkg::*;

  logic [3:0] hi1, lo1, hi2, lo2, hi3, lo3;

  always_comb begin
    hi1  = nib_lut(P_BOX, din[7:4]);
    lo1  = nib_lut(Q_BOX, din[3:0]);
    hi2  = nib_lut(Q_BOX, {hi1[3:2], lo1[3:2]});
    lo2  = nib_lut(P_BOX, {hi1[1:0], lo1[1:0]});
    hi3  = nib_lut(P_BOX, {hi2[3:2], lo2[3:2]});
    lo3  = nib_lut(Q_BOX, {hi2[1:0], lo2[1:0]});
    dout = {hi3, lo3};
  end
endmodule

// File: rtl/spn96_round.sv
module spn96_round #(
  parameter logic [63:0] P_BOX = 64'h3FE054BCDA967821,
  parameter logic [63:0] Q_BOX = 64'h9E5D4C7A8B2F1036
) (
  input  logic [spn96_pkg::BLK_W-1:0] st_in,
  input  logic [spn96_pkg::BLK_W-1:0] rkey,
  input  logic                        last,
  output logic [spn96_pkg::BLK_W-1:0] st_out
);
  import spn96_pkg::*;

  logic [BLK_W-1:0] sub_w, perm_w, mix_w;

  // substitution layer
  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    spn96_sbox #(.P_BOX(P_BOX), .Q_BOX(Q_BOX)) sbox_i (
      .din  (st_in[8*b +: 8]),
      .dout (sub_w[8*b +: 8])
    );
  end

  // in-row swaps; element (i,j) at byte i+3j
  for (genvar i = 0; i < ROWS; i++) begin : g_prow
    for (genvar j = 0; j < COLS; j++) begin : g_pcol
      localparam int SRC_J = j ^ row_swap(i);
      assign perm_w[8*(i+ROWS*j) +: 8] = sub_w[8*(i+ROWS*SRC_J) +: 8];
    end
  end

  // column mixing through a shared parity byte
  for (genvar j = 0; j < COLS; j++) begin : g_mix
    logic [7:0] b0, b1, b2, par, d1, d2;
    always_comb begin
      b0  = perm_w[8*(ROWS*j)     +: 8];
      b1  = perm_w[8*(ROWS*j + 1) +: 8];
      b2  = perm_w[8*(ROWS*j + 2) +: 8];
      par = b0 ^ b1 ^ b2;
      d1  = gf_dbl(par);
      d2  = gf_dbl(d1);
    end
    assign mix_w[8*(ROWS*j)     +: 8] = b0 ^ d1;
    assign mix_w[8*(ROWS*j + 1) +: 8] = b1 ^ d2;
    assign mix_w[8*(ROWS*j + 2) +: 8] = b2 ^ d1 ^ d2;
  end

  assign st_out = (last ? perm_w : mix_w) ^ rkey;
endmodule

// File: rtl/spn96_core.sv
module spn96_core #(
  parameter int          ROUNDS = 10,
  parameter logic [63:0] P_BOX  = 64'h3FE054BCDA967821,
  parameter logic [63:0] Q_BOX  = 64'h9E5D4C7A8B2F1036,
  localparam int         CNT_W  = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [95:0]      blk_in,
  input  logic [95:0]      subkey,
  output logic [CNT_W-1:0] key_sel,
  output logic             busy,
  output logic             done,
  output logic [95:0]      blk_out
);
  import spn96_pkg::*;

  logic [BLK_W-1:0] st_q, rnd_out, out_q;
  logic [CNT_W-1:0] rnd_q;
  logic             busy_q, done_q, last_w;

  assign last_w = (rnd_q == CNT_W'(ROUNDS));

  spn96_round #(.P_BOX(P_BOX), .Q_BOX(Q_BOX)) round_i (
    .st_in  (st_q),
    .rkey   (subkey),
    .last   (last_w),
    .st_out (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      out_q  <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          st_q   <= blk_in ^ subkey;
          rnd_q  <= CNT_W'(1);
          busy_q <= 1'b1;
        end
      end else begin
        st_q <= rnd_out;
        if (last_w) begin
          out_q  <= rnd_out;
          rnd_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + CNT_W'(1);
        end
      end
    end
  end

  assign key_sel = rnd_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign blk_out = out_q;

  // R8: an accepted strobe starts the count at one
  p_launch_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && key_sel == CNT_W'(1)));

  // R8, R10: mid-run cycles advance by exactly one regardless of start
  p_round_step_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && key_sel != CNT_W'(ROUNDS)) |=> (busy && key_sel == $past(key_sel) + CNT_W'(1)));

  // R9: completion pulse is one cycle wide
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: never busy while signalling completion
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: output moves only with a completion pulse
  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(blk_out));
endmodule

// File: tb/spn96_core_tb.sv
`timescale 1ns/1ps
module spn96_core_tb_top;
  localparam int          NR   = 10;
  localparam logic [63:0] PTAB = 64'h3FE054BCDA967821;
  localparam logic [63:0] QTAB = 64'h9E5D4C7A8B2F1036;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [95:0] blk_in = '0;
  logic [95:0] subkey;
  logic [3:0]  key_sel;
  logic        busy, done;
  logic [95:0] blk_out;
  logic [95:0] keys [0:NR];

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  always_comb subkey = keys[key_sel];

  spn96_core #(.ROUNDS(NR), .P_BOX(PTAB), .Q_BOX(QTAB)) dut_i (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in), .subkey(subkey),
    .key_sel(key_sel), .busy(busy), .done(done), .blk_out(blk_out)
  );

  function automatic logic [3:0] lut(input logic [63:0] t, input logic [3:0] i);
    return t[4*i +: 4];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] u);
    logic [3:0] h, l, h2, l2;
    h  = lut(PTAB, u[7:4]);
    l  = lut(QTAB, u[3:0]);
    h2 = lut(QTAB, {h[3:2], l[3:2]});
    l2 = lut(PTAB, {h[1:0], l[1:0]});
    return {lut(PTAB, {h2[3:2], l2[3:2]}), lut(QTAB, {h2[1:0], l2[1:0]})};
  endfunction

  function automatic logic [7:0] m_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h4D : 8'h00);
  endfunction

  function automatic logic [95:0] m_round(input logic [95:0] st, input logic [95:0] k, input bit fin);
    logic [95:0] s, p, m;
    for (int b = 0; b < 12; b++) s[8*b +: 8] = m_sbox(st[8*b +: 8]);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 4; j++) begin
        int sj;
        sj = (i == 0) ? j : ((i == 1) ? (j ^ 1) : (j ^ 2));
        p[8*(i+3*j) +: 8] = s[8*(i+3*sj) +: 8];
      end
    m = p;
    if (!fin)
      for (int j = 0; j < 4; j++) begin
        logic [7:0] v, d1, d2;
        v  = p[8*(3*j) +: 8] ^ p[8*(3*j+1) +: 8] ^ p[8*(3*j+2) +: 8];
        d1 = m_dbl(v);
        d2 = m_dbl(d1);
        m[8*(3*j)   +: 8] = p[8*(3*j)   +: 8] ^ d1;
        m[8*(3*j+1) +: 8] = p[8*(3*j+1) +: 8] ^ d2;
        m[8*(3*j+2) +: 8] = p[8*(3*j+2) +: 8] ^ d1 ^ d2;
      end
    return m ^ k;
  endfunction

  function automatic logic [95:0] m_enc(input logic [95:0] pt);
    logic [95:0] st;
    st = pt ^ keys[0];
    for (int r = 1; r <= NR; r++) st = m_round(st, keys[r], r == NR);
    return st;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rand_keys();
    for (int r = 0; r <= NR; r++) keys[r] = {$urandom, $urandom, $urandom};
  endtask

  // run one block; optionally pulse start again at cycle mid
  task automatic run_block(input logic [95:0] pt, input int mid, input logic [95:0] other);
    logic [95:0] exp;
    int k;
    exp = m_enc(pt);
    @(negedge clk);
    blk_in = pt;
    start  = 1'b1;
    k = 0;
    while (k < 40) begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (k == mid) begin start = 1'b1; blk_in = other; end
      if (done) break;
    end
    start = 1'b0;
    chk(k - 1 == NR, "R8 latency", 96'(k - 1), 96'(NR));
    chk(blk_out == exp, "R2 R3 R4 R5 R6 R7 result", blk_out, exp);
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", {94'd0, done, busy}, 96'd0);
    if (mid > 0) begin
      for (int w = 0; w < 14; w++) begin
        chk(!busy && !done, "R10 ignored start", {94'd0, busy, done}, 96'd0);
        @(negedge clk);
      end
    end
    for (int w = 0; w < 3; w++) @(negedge clk);
    chk(blk_out == exp, "R11 output held", blk_out, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r <= NR; r++) keys[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 flags after reset", {94'd0, busy, done}, 96'd0);
    chk(key_sel == 4'd0, "R1 key_sel after reset", 96'(key_sel), 96'd0);
    chk(blk_out == '0, "R1 blk_out after reset", blk_out, 96'd0);

    // directed: zero data and keys
    run_block('0, 0, '0);
    // directed: all ones
    for (int r = 0; r <= NR; r++) keys[r] = '1;
    run_block('1, 0, '0);
    // directed: single bit in row 2 col 3, zero keys (R2 mapping)
    for (int r = 0; r <= NR; r++) keys[r] = '0;
    run_block(96'h1 << (8*(2+3*3)), 0, '0);
    // directed: key only on round 0 (R3)
    keys[0] = 96'hA5A5_0000_FFFF_1234_5678_9ABC;
    run_block('0, 0, '0);
    // start while busy, twice at different points (R10)
    rand_keys();
    run_block({$urandom, $urandom, $urandom}, 4, '1);
    rand_keys();
    run_block({$urandom, $urandom, $urandom}, 9, 96'h123);
    // random blocks
    for (int n = 0; n < 24; n++) begin
      rand_keys();
      run_block({$urandom, $urandom, $urandom}, 0, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule